// File: doc/BRIEF.md
# Signal-Driven Hardware Task Scheduler

This block sits beside an 8-bit controller core and decides which of a small set of cooperating tasks runs. The core sends one command per cycle: pause, resume, spawn, exit, getpid or status. Each command names a signal (0 to 15) or a process ID (0 to 7). The block answers with the current task's ID and the address at which that task must continue. Tasks block on numbered signals. Each signal has a single wait slot. A priority stack of preempted task IDs decides who runs when the current task pauses or ends.

A resume behaves like a call into the woken task. The caller is pushed on the stack with its return address. It continues only when the woken task pauses again or terminates. Spawn works the same way for a newly created task. Interrupt handlers reach the block only as resume commands, so a resume that arrives while no task runs wakes the waiting task without pushing anything. Each task's saved continuation address and exit address are held in per-ID tables inside the block. An exit aimed at another task marks that task aborted, and an aborted task always re-enters at its exit address.

Top module: `task_sched`

## Requirements
- R1: After reset, task 0 is current and running at `MAIN_START`, with exit address `MAIN_EXIT`. All other IDs are free, all wait slots and the stack are empty, and `idle_o`, `err_o`, `switch_o` and `result_o` are 0.
- R2: Pause (op 0) on signal S parks the current task in slot S and saves `cmd_pc_i` as its continuation. The task on top of the stack is then popped and becomes current. If the stack is empty, `idle_o` rises. `switch_o` pulses for one cycle.
- R3: A pause on a signal whose slot is occupied, or a pause while idle, is refused. `err_o` is set and the current task, its address and all slots are unchanged.
- R4: Resume (op 1) on signal S makes the task parked on S current at its saved continuation address. The caller, if any, is pushed with `cmd_pc_i` as its return address. When the woken task later pauses or exits, the caller continues at that address.
- R5: A resume on an empty slot has no effect apart from setting `err_o`.
- R6: Spawn (op 2) takes the lowest free ID, writes it to `result_o` and pushes the caller with `cmd_pc_i` saved. The new task then starts at `cmd_addr_i`, and `cmd_exit_i` is recorded as its exit address.
- R7: A spawn with no free ID writes 0xFF to `result_o`, performs no switch and leaves `err_o` at 0.
- R8: Exit (op 3) naming a live ID other than the current one marks it aborted and does not switch. When an aborted task next becomes current, by resume or by stack pop, it continues at its exit address.
- R9: Exit naming the current task frees its ID and pops the stack as a pause does. With an empty stack, `idle_o` rises. An exit naming a free ID has no effect.
- R10: Getpid (op 4) writes the current ID to `result_o`, or 0xFF while idle.
- R11: Status (op 5) writes a code for the named ID to `result_o`: 0 free, 1 running, 2 parked on a signal, 3 preempted on the stack, 4 aborted (which takes precedence over the others). An ID out of range gives 0xFF.
- R12: A resume or spawn that would push onto a full stack (depth `STK_DEPTH`) is refused with `err_o` set, and no switch takes place.
- R13: Outputs are registered and reflect a command one clock after it is accepted. `err_o` reports the most recent command only. Op codes 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 3 | Command code (0 pause, 1 resume, 2 spawn, 3 exit, 4 getpid, 5 status) |
| cmd_arg_i | input | ARG_W | Signal number or process ID |
| cmd_pc_i | input | ADDR_W | Continuation address of the issuing task |
| cmd_addr_i | input | ADDR_W | Start address for spawn |
| cmd_exit_i | input | ADDR_W | Exit address for spawn |
| cur_pid_o | output | PID_W | Current task ID |
| cur_pc_o | output | ADDR_W | Address at which the current task continues |
| idle_o | output | 1 | No task is current |
| switch_o | output | 1 | One-cycle pulse when control changed hands |
| result_o | output | 8 | Result of spawn, getpid or status |
| err_o | output | 1 | Last command was refused |

## Verification
The bench builds the block with a stack depth of 4 so that overflow can be reached with few tasks. It drives four kinds of command patterns.

A pause followed by a resume from the idle state, and a nested spawn, pause, resume and self-exit chain, tell apart the idle wake-up and the caller-return paths. A run that fills every ID and then frees one in the middle checks that the lowest free ID is chosen, rather than the next one in sequence. Conflict cases, aborts and a spawn chain four levels deep tell refusal, exit-address re-entry and overflow apart from normal switches.

// File: rtl/sched_pkg.sv
package sched_pkg;
  localparam logic [2:0] OP_PAUSE  = 3'd0;
  localparam logic [2:0] OP_RESUME = 3'd1;
  localparam logic [2:0] OP_SPAWN  = 3'd2;
  localparam logic [2:0] OP_EXIT   = 3'd3;
  localparam logic [2:0] OP_GETPID = 3'd4;
  localparam logic [2:0] OP_STATUS = 3'd5;

  localparam logic [7:0] RES_NONE    = 8'hFF;
  localparam logic [7:0] RES_ABORTED = 8'd4;

  typedef enum logic [1:0] {
    ST_FREE    = 2'd0,
    ST_RUN     = 2'd1,
    ST_PARKED  = 2'd2,
    ST_STACKED = 2'd3
  } task_state_e;
endpackage

// File: rtl/sched_free_find.sv
module sched_free_find #(
  parameter int N = 8,
  parameter int W = 3
) (
  input  logic [N-1:0] free_i,
  output logic         found_o,
  output logic [W-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (free_i[i]) begin
        found_o = 1'b1;
        idx_o   = W'(i);
      end
    end
  end

  // R6
  always_comb begin
    if (found_o) begin
      free_pick_chk: assert (free_i[idx_o]);
    end
  end
endmodule

// File: rtl/sched_prio_stack.sv
module sched_prio_stack #(
  parameter int DEPTH = 8,
  parameter int ID_W  = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push_i,
  input  logic [ID_W-1:0] push_id_i,
  input  logic            pop_i,
  output logic [ID_W-1:0] top_id_o,
  output logic            empty_o,
  output logic            full_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [ID_W-1:0]  mem_q [DEPTH];
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] top_cnt;
  logic             wr_en;

  assign empty_o  = (cnt_q == '0);
  assign full_o   = (cnt_q == CNT_W'(DEPTH));
  assign top_cnt  = cnt_q - 1'b1;
  assign top_id_o = mem_q[top_cnt[IDX_W-1:0]];
  assign wr_en    = push_i && !full_o;

  always_comb begin
    cnt_d = cnt_q;
    if (wr_en) begin
      cnt_d = cnt_q + 1'b1;
    end else if (pop_i && !empty_o) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (wr_en) begin
        mem_q[cnt_q[IDX_W-1:0]] <= push_id_i;
      end
    end
  end

  // R12
  stk_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> !full_o);
  // R2
  stk_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> !empty_o);
  // R4
  stk_push_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |=> !empty_o && top_id_o == $past(push_id_i));
endmodule

// File: rtl/sched_wait_slots.sv
module sched_wait_slots #(
  parameter int NUM_SIG = 16,
  parameter int ID_W    = 3,
  localparam int SIG_W  = $clog2(NUM_SIG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SIG_W-1:0] sel_i,
  input  logic             park_i,
  input  logic [ID_W-1:0]  park_id_i,
  input  logic             clr_i,
  output logic             occ_o,
  output logic [ID_W-1:0]  id_o
);
  logic [NUM_SIG-1:0] occ_q;
  logic [ID_W-1:0]    id_q [NUM_SIG];

  for (genvar s = 0; s < NUM_SIG; s++) begin : g_slot
    logic hit;
    assign hit = (sel_i == SIG_W'(s));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        occ_q[s] <= 1'b0;
        id_q[s]  <= '0;
      end else if (park_i && hit) begin
        occ_q[s] <= 1'b1;
        id_q[s]  <= park_id_i;
      end else if (clr_i && hit) begin
        occ_q[s] <= 1'b0;
      end
    end
  end

  assign occ_o = occ_q[sel_i];
  assign id_o  = id_q[sel_i];

  // R3
  slot_no_double_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    park_i |-> !occ_o);
  // R5
  slot_clear_occupied_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |-> occ_o);
  // R2
  slot_park_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    park_i |=> occ_q[$past(sel_i)]);
endmodule

// File: rtl/task_sched.sv
module task_sched
  import sched_pkg::*;
#(
  parameter int NUM_SIG   = 16,
  parameter int NUM_PID   = 8,
  parameter int STK_DEPTH = 8,
  parameter int ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] MAIN_START = 'h0100,
  parameter logic [ADDR_W-1:0] MAIN_EXIT  = 'h0F00,
  localparam int SIG_W = $clog2(NUM_SIG),
  localparam int PID_W = $clog2(NUM_PID),
  localparam int ARG_W = (SIG_W > PID_W) ? SIG_W : PID_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid_i,
  input  logic [2:0]        cmd_op_i,
  input  logic [ARG_W-1:0]  cmd_arg_i,
  input  logic [ADDR_W-1:0] cmd_pc_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [ADDR_W-1:0] cmd_exit_i,
  output logic [PID_W-1:0]  cur_pid_o,
  output logic [ADDR_W-1:0] cur_pc_o,
  output logic              idle_o,
  output logic              switch_o,
  output logic [7:0]        result_o,
  output logic              err_o
);
  // reset synchronizer: asserts at once, releases on the clock
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // task state
  logic                cur_valid_q, cur_valid_d;
  logic [PID_W-1:0]    cur_pid_q, cur_pid_d;
  logic [ADDR_W-1:0]   cur_pc_q, cur_pc_d;
  task_state_e         state_q [NUM_PID];
  task_state_e         state_d [NUM_PID];
  logic [NUM_PID-1:0]  abort_q, abort_d;
  logic [ADDR_W-1:0]   pc_q [NUM_PID];
  logic [ADDR_W-1:0]   pc_d [NUM_PID];
  logic [ADDR_W-1:0]   exit_q [NUM_PID];
  logic [ADDR_W-1:0]   exit_d [NUM_PID];
  logic [7:0]          result_q, result_d;
  logic                err_q, err_d;
  logic                sw_q, sw_d;

  // sub-block wiring
  logic               stk_push, stk_pop, stk_empty, stk_full;
  logic [PID_W-1:0]   stk_top;
  logic               slot_park, slot_clr, slot_occ;
  logic [PID_W-1:0]   slot_id;
  logic [NUM_PID-1:0] free_vec;
  logic               free_found;
  logic [PID_W-1:0]   free_idx;
  logic [PID_W-1:0]   arg_pid;
  logic               arg_in_range;
  logic               do_pop;

  assign arg_pid      = cmd_arg_i[PID_W-1:0];
  assign arg_in_range = ({1'b0, cmd_arg_i} < (ARG_W + 1)'(NUM_PID));

  for (genvar p = 0; p < NUM_PID; p++) begin : g_free
    assign free_vec[p] = (state_q[p] == ST_FREE);
  end

  sched_free_find #(.N(NUM_PID), .W(PID_W)) u_free (
    .free_i  (free_vec),
    .found_o (free_found),
    .idx_o   (free_idx)
  );

  sched_prio_stack #(.DEPTH(STK_DEPTH), .ID_W(PID_W)) u_stack (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .push_i    (stk_push),
    .push_id_i (cur_pid_q),
    .pop_i     (stk_pop),
    .top_id_o  (stk_top),
    .empty_o   (stk_empty),
    .full_o    (stk_full)
  );

  sched_wait_slots #(.NUM_SIG(NUM_SIG), .ID_W(PID_W)) u_slots (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .sel_i     (cmd_arg_i[SIG_W-1:0]),
    .park_i    (slot_park),
    .park_id_i (cur_pid_q),
    .clr_i     (slot_clr),
    .occ_o     (slot_occ),
    .id_o      (slot_id)
  );

  // next-state logic
  always_comb begin
    cur_valid_d = cur_valid_q;
    cur_pid_d   = cur_pid_q;
    cur_pc_d    = cur_pc_q;
    state_d     = state_q;
    abort_d     = abort_q;
    pc_d        = pc_q;
    exit_d      = exit_q;
    result_d    = result_q;
    err_d       = err_q;
    sw_d        = 1'b0;
    stk_push    = 1'b0;
    stk_pop     = 1'b0;
    slot_park   = 1'b0;
    slot_clr    = 1'b0;
    do_pop      = 1'b0;

    if (cmd_valid_i) begin
      err_d = 1'b0;
      case (cmd_op_i)
        OP_PAUSE: begin
          if (!cur_valid_q || slot_occ) begin
            err_d = 1'b1;
          end else begin
            slot_park          = 1'b1;
            state_d[cur_pid_q] = ST_PARKED;
            pc_d[cur_pid_q]    = cmd_pc_i;
            do_pop             = 1'b1;
          end
        end
        OP_RESUME: begin
          if (!slot_occ || (cur_valid_q && stk_full)) begin
            err_d = 1'b1;
          end else begin
            slot_clr = 1'b1;
            if (cur_valid_q) begin
              stk_push           = 1'b1;
              state_d[cur_pid_q] = ST_STACKED;
              pc_d[cur_pid_q]    = cmd_pc_i;
            end
            cur_valid_d      = 1'b1;
            cur_pid_d        = slot_id;
            state_d[slot_id] = ST_RUN;
            cur_pc_d         = abort_q[slot_id] ? exit_q[slot_id] : pc_q[slot_id];
            sw_d             = 1'b1;
          end
        end
        OP_SPAWN: begin
          if (!free_found) begin
            result_d = RES_NONE;
          end else if (cur_valid_q && stk_full) begin
            err_d = 1'b1;
          end else begin
            if (cur_valid_q) begin
              stk_push           = 1'b1;
              state_d[cur_pid_q] = ST_STACKED;
              pc_d[cur_pid_q]    = cmd_pc_i;
            end
            result_d          = 8'(free_idx);
            state_d[free_idx] = ST_RUN;
            abort_d[free_idx] = 1'b0;
            exit_d[free_idx]  = cmd_exit_i;
            cur_valid_d       = 1'b1;
            cur_pid_d         = free_idx;
            cur_pc_d          = cmd_addr_i;
            sw_d              = 1'b1;
          end
        end
        OP_EXIT: begin
          if (arg_in_range && state_q[arg_pid] != ST_FREE) begin
            if (cur_valid_q && arg_pid == cur_pid_q) begin
              state_d[arg_pid] = ST_FREE;
              abort_d[arg_pid] = 1'b0;
              do_pop           = 1'b1;
            end else begin
              abort_d[arg_pid] = 1'b1;
            end
          end
        end
        OP_GETPID: begin
          result_d = cur_valid_q ? 8'(cur_pid_q) : RES_NONE;
        end
        OP_STATUS: begin
          if (!arg_in_range) begin
            result_d = RES_NONE;
          end else if (abort_q[arg_pid]) begin
            result_d = RES_ABORTED;
          end else begin
            result_d = 8'(state_q[arg_pid]);
          end
        end
        default: begin
        end
      endcase

      if (do_pop) begin
        sw_d = 1'b1;
        if (!stk_empty) begin
          stk_pop          = 1'b1;
          cur_valid_d      = 1'b1;
          cur_pid_d        = stk_top;
          state_d[stk_top] = ST_RUN;
          cur_pc_d         = abort_q[stk_top] ? exit_q[stk_top] : pc_q[stk_top];
        end else begin
          cur_valid_d = 1'b0;
        end
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cur_valid_q <= 1'b1;
      cur_pid_q   <= '0;
      cur_pc_q    <= MAIN_START;
      abort_q     <= '0;
      result_q    <= '0;
      err_q       <= 1'b0;
      sw_q        <= 1'b0;
      for (int i = 0; i < NUM_PID; i++) begin
        state_q[i] <= (i == 0) ? ST_RUN : ST_FREE;
        pc_q[i]    <= '0;
        exit_q[i]  <= (i == 0) ? MAIN_EXIT : '0;
      end
    end else begin
      cur_valid_q <= cur_valid_d;
      cur_pid_q   <= cur_pid_d;
      cur_pc_q    <= cur_pc_d;
      abort_q     <= abort_d;
      result_q    <= result_d;
      err_q       <= err_d;
      sw_q        <= sw_d;
      state_q     <= state_d;
      pc_q        <= pc_d;
      exit_q      <= exit_d;
    end
  end

  assign cur_pid_o = cur_pid_q;
  assign cur_pc_o  = cur_pc_q;
  assign idle_o    = !cur_valid_q;
  assign switch_o  = sw_q;
  assign result_o  = result_q;
  assign err_o     = err_q;

  // R5
  resume_empty_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmd_valid_i && cmd_op_i == OP_RESUME && !slot_occ)
      |=> err_o && !switch_o && $stable(cur_pid_o) && $stable(cur_pc_o));
  // R7
  spawn_none_free_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmd_valid_i && cmd_op_i == OP_SPAWN && free_vec == '0)
      |=> result_o == 8'hFF && !switch_o && !err_o);
  // R3
  pause_conflict_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmd_valid_i && cmd_op_i == OP_PAUSE && slot_occ)
      |=> err_o && $stable(cur_pid_o) && $stable(idle_o));
  // R13
  switch_pulse_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cmd_valid_i |=> !switch_o && $stable(cur_pid_o) && $stable(cur_pc_o));
endmodule

// File: tb/sim_task_sched.sv
`timescale 1ns/1ps
module sim_task_sched;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid_i;
  logic [2:0]  cmd_op_i;
  logic [3:0]  cmd_arg_i;
  logic [15:0] cmd_pc_i, cmd_addr_i, cmd_exit_i;
  logic [2:0]  cur_pid_o;
  logic [15:0] cur_pc_o;
  logic        idle_o, switch_o, err_o;
  logic [7:0]  result_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  task_sched #(.STK_DEPTH(4)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i),
    .cmd_arg_i(cmd_arg_i), .cmd_pc_i(cmd_pc_i), .cmd_addr_i(cmd_addr_i),
    .cmd_exit_i(cmd_exit_i), .cur_pid_o(cur_pid_o), .cur_pc_o(cur_pc_o),
    .idle_o(idle_o), .switch_o(switch_o), .result_o(result_o), .err_o(err_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    cmd_valid_i = 1'b0; cmd_op_i = '0; cmd_arg_i = '0;
    cmd_pc_i = '0; cmd_addr_i = '0; cmd_exit_i = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic cmd(input logic [2:0] op, input logic [3:0] arg, input logic [15:0] pc,
                     input logic [15:0] addr = 16'h0, input logic [15:0] ex = 16'h0);
    @(negedge clk);
    cmd_valid_i = 1'b1; cmd_op_i = op; cmd_arg_i = arg;
    cmd_pc_i = pc; cmd_addr_i = addr; cmd_exit_i = ex;
    @(negedge clk);
    cmd_valid_i = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 pid", cur_pid_o, 0);
    check("R1 pc", cur_pc_o, 16'h0100);
    check("R1 idle", idle_o, 0);
    check("R1 err", err_o, 0);
    check("R1 result", result_o, 0);
    check("R1 switch", switch_o, 0);
    cmd(3'd5, 4'd0, 0);
    check("R11 status running", result_o, 1);
    cmd(3'd5, 4'd1, 0);
    check("R11 status free", result_o, 0);
    cmd(3'd5, 4'd9, 0);
    check("R11 status out of range", result_o, 8'hFF);
    cmd(3'd6, 4'd2, 16'h0777);
    check("R13 op6 result", result_o, 8'hFF);
    check("R13 op6 pc", cur_pc_o, 16'h0100);
    check("R13 op6 switch", switch_o, 0);
    cmd(3'd7, 4'd0, 16'h0777);
    check("R13 op7 idle", idle_o, 0);
    check("R13 op7 err", err_o, 0);
  endtask

  task automatic t_pause_resume();
    do_reset();
    cmd(3'd0, 4'd3, 16'h0123);
    check("R2 idle after pause", idle_o, 1);
    check("R2 switch", switch_o, 1);
    cmd(3'd5, 4'd0, 0);
    check("R11 status parked", result_o, 2);
    cmd(3'd4, 4'd0, 0);
    check("R10 getpid idle", result_o, 8'hFF);
    cmd(3'd1, 4'd3, 16'h9999);
    check("R4 wake from idle pid", cur_pid_o, 0);
    check("R4 wake from idle pc", cur_pc_o, 16'h0123);
    check("R4 wake idle low", idle_o, 0);
    cmd(3'd2, 4'd0, 16'h0130, 16'h0200, 16'h0280);
    check("R6 spawn id", result_o, 1);
    check("R6 spawn pid", cur_pid_o, 1);
    check("R6 spawn pc", cur_pc_o, 16'h0200);
    cmd(3'd5, 4'd0, 0);
    check("R11 status stacked", result_o, 3);
    cmd(3'd0, 4'd5, 16'h0210);
    check("R2 pop pid", cur_pid_o, 0);
    check("R2 pop pc", cur_pc_o, 16'h0130);
    cmd(3'd1, 4'd5, 16'h0140);
    check("R4 woken pid", cur_pid_o, 1);
    check("R4 woken pc", cur_pc_o, 16'h0210);
    cmd(3'd3, 4'd1, 16'h0);
    check("R9 return pid", cur_pid_o, 0);
    check("R4 return to caller pc", cur_pc_o, 16'h0140);
    cmd(3'd5, 4'd1, 0);
    check("R9 freed", result_o, 0);
    cmd(3'd4, 4'd0, 0);
    check("R10 getpid", result_o, 0);
    cmd(3'd3, 4'd5, 0);
    check("R9 exit free id no switch", switch_o, 0);
    cmd(3'd3, 4'd0, 0);
    check("R9 main exit idle", idle_o, 1);
  endtask

  task automatic t_errors();
    do_reset();
    cmd(3'd2, 4'd0, 16'h0150, 16'h0300, 16'h0380);
    cmd(3'd0, 4'd2, 16'h0310);
    check("R2 back to main", cur_pid_o, 0);
    cmd(3'd0, 4'd2, 16'h0160);
    check("R3 pause conflict err", err_o, 1);
    check("R3 pause conflict pid", cur_pid_o, 0);
    check("R3 pause conflict pc", cur_pc_o, 16'h0150);
    check("R3 pause conflict no switch", switch_o, 0);
    cmd(3'd1, 4'd9, 16'h0170);
    check("R5 empty resume err", err_o, 1);
    check("R5 empty resume pc", cur_pc_o, 16'h0150);
    cmd(3'd4, 4'd0, 0);
    check("R13 err cleared", err_o, 0);
    cmd(3'd1, 4'd2, 16'h0180);
    check("R3 slot 2 kept task 1", cur_pc_o, 16'h0310);
    cmd(3'd3, 4'd1, 0);
    cmd(3'd3, 4'd0, 0);
    check("R9 idle", idle_o, 1);
    cmd(3'd0, 4'd4, 16'h0190);
    check("R3 pause while idle err", err_o, 1);
    check("R3 pause while idle stays idle", idle_o, 1);
  endtask

  task automatic t_exhaust();
    do_reset();
    for (int k = 1; k < 8; k++) begin
      cmd(3'd2, 4'd0, 16'h0500, 16'h2000 + 16'(k), 16'h3000);
      if (k == 7) check("R6 spawn id seven", result_o, 7);
      cmd(3'd0, 4'(k), 16'h0200 + 16'(k * 16));
    end
    cmd(3'd2, 4'd0, 16'h0510, 16'h4000, 16'h4100);
    check("R7 none free result", result_o, 8'hFF);
    check("R7 none free pid", cur_pid_o, 0);
    check("R7 none free switch", switch_o, 0);
    check("R7 none free err", err_o, 0);
    cmd(3'd1, 4'd3, 16'h0520);
    check("R4 resume pid 3", cur_pc_o, 16'h0230);
    cmd(3'd3, 4'd3, 0);
    check("R9 back to main pc", cur_pc_o, 16'h0520);
    cmd(3'd2, 4'd0, 16'h0530, 16'h4000, 16'h4100);
    check("R6 lowest free", result_o, 3);
    check("R6 lowest free pc", cur_pc_o, 16'h4000);
  endtask

  task automatic t_abort();
    do_reset();
    cmd(3'd2, 4'd0, 16'h0600, 16'h0400, 16'h0480);
    cmd(3'd0, 4'd4, 16'h0410);
    cmd(3'd3, 4'd1, 16'h0610);
    check("R8 no switch", switch_o, 0);
    check("R8 stays main", cur_pid_o, 0);
    cmd(3'd5, 4'd1, 0);
    check("R11 status aborted", result_o, 4);
    cmd(3'd1, 4'd4, 16'h0620);
    check("R8 resume pid", cur_pid_o, 1);
    check("R8 resume to exit address", cur_pc_o, 16'h0480);
  endtask

  task automatic t_overflow();
    do_reset();
    for (int k = 0; k < 4; k++) begin
      cmd(3'd2, 4'd0, 16'h0A00 + 16'(k * 16), 16'h0B00 + 16'(k), 16'h0C00);
    end
    check("R6 chain pid", cur_pid_o, 4);
    cmd(3'd2, 4'd0, 16'h0A40, 16'h0D00, 16'h0C00);
    check("R12 overflow err", err_o, 1);
    check("R12 overflow pid", cur_pid_o, 4);
    check("R12 overflow switch", switch_o, 0);
    check("R12 overflow result", result_o, 4);
    cmd(3'd3, 4'd4, 0);
    check("R9 pop after overflow pid", cur_pid_o, 3);
    check("R9 pop after overflow pc", cur_pc_o, 16'h0A30);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_pause_resume();
    t_errors();
    t_exhaust();
    t_abort();
    t_overflow();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule